// File: doc/BRIEF.md
# Banked Memory Split/Merge Controller

This controller sits between one processor memory port and eight single-port SRAM banks. Each request carries a word address. The low address bits choose the bank and the upper bits choose the word inside that bank. The controller forwards each request to its bank as a one-cycle enable pulse. Only the chosen bank sees that pulse, so the other banks stay quiet.

A bank finishes its operation after a latency it decides itself, anywhere from one to four cycles, and signals this with a completion pulse. While one bank is busy, the controller keeps accepting requests that target other banks, so up to one operation per bank can be in flight at once. A request to a bank that is still occupied holds the request channel until that bank frees up.

Read data from all the banks is merged onto a single response channel in the order the reads were accepted, whatever order the banks finish in. Writes occupy their bank until it completes and never produce a response.

Top module: `membank_router`

## Requirements
- R1: After reset no bank enable is high, `rsp_valid_o` is low and `req_ready_o` is high.
- R2: A request accepted on a clock edge (`req_valid_i` and `req_ready_o` both high) drives exactly one `bank_en_o` bit high in the following cycle. That bit is the one given by `req_addr_i[2:0]`. In the same cycle `bank_row_o` equals `req_addr_i[10:3]`, and `bank_we_o` and `bank_wdata_o` equal the request's write flag and data.
- R3: In any cycle at most one `bank_en_o` bit is high, and a bank whose index was not addressed by the request accepted on the previous edge keeps its enable low.
- R4: `req_ready_o` is low while the addressed bank is occupied. A write occupies its bank from acceptance until the edge that samples that bank's `bank_done_i`. A read occupies its bank from acceptance until the edge on which its response is presented.
- R5: Requests to eight distinct free banks are accepted on eight consecutive cycles while the earlier ones are still outstanding.
- R6: Read responses appear on `rsp_valid_o`/`rsp_data_o` in the order the reads were accepted, even when a later read's bank finishes first.
- R7: A read's response is valid for one cycle. That cycle follows the later of two edges: the edge that samples its bank's `bank_done_i`, and the edge on which the previous read's response was presented.
- R8: A write never produces a response on `rsp_valid_o`.
- R9: For any bank latency from 1 to 4 cycles, a read returns the data last written to that address. That data is what the bank put on its 16-bit lane `bank_rdata_i[16*b +: 16]` in the cycle `bank_done_i[b]` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be taken this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 11 | Word address; bits 2:0 pick the bank, bits 10:3 the word |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_data_o | output | 16 | Read data |
| bank_en_o | output | 8 | One-cycle operation strobe per bank |
| bank_we_o | output | 1 | Write flag for the strobed bank |
| bank_row_o | output | 8 | Word index within the strobed bank |
| bank_wdata_o | output | 16 | Write data for the strobed bank |
| bank_done_i | input | 8 | Per-bank completion pulse |
| bank_rdata_i | input | 128 | Per-bank read data, 16 bits per bank, valid with its done pulse |

## Verification
The bench makes banks finish out of order by giving early requests the longest latency and later ones the shortest. A controller that merged responses in completion order, instead of acceptance order, would return data swapped between addresses. Back-to-back requests to one bank probe the occupancy window. A design that freed a read's bank on completion, rather than on delivery, could accept a second read and overwrite the first result before it was sent. A design that ignored occupancy altogether would strobe a busy bank twice. Write-only bursts and single-cycle bank latency check that writes never raise a response. They also check that a completion pulse arriving right after the enable is still caught.

// File: rtl/membank_pkg.sv
package membank_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_WR   = 2'd1,
    SLOT_RD   = 2'd2,
    SLOT_FULL = 2'd3
  } slot_state_e;
endpackage

// File: rtl/membank_slot.sv
module membank_slot
  import membank_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              issue_we_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              pop_i,
  output logic              busy_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  slot_state_e       state_q, state_d;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SLOT_IDLE: if (issue_i) state_d = issue_we_i ? SLOT_WR : SLOT_RD;
      SLOT_WR:   if (done_i)  state_d = SLOT_IDLE;
      SLOT_RD:   if (done_i)  state_d = SLOT_FULL;
      SLOT_FULL: if (pop_i)   state_d = SLOT_IDLE;
      default:                state_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SLOT_IDLE;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SLOT_RD && done_i) data_q <= rdata_i;
    end
  end

  // read slot stays busy until its word has been merged out
  assign busy_o = (state_q != SLOT_IDLE);
  assign full_o = (state_q == SLOT_FULL);
  assign data_o = data_q;
endmodule

// File: rtl/membank_order_fifo.sv
module membank_order_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_ptr_q] <= din_i;
        wr_ptr_q        <= ptr_inc(wr_ptr_q);
      end
      if (do_pop) rd_ptr_q <= ptr_inc(rd_ptr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CNT_W'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/membank_drive.sv
module membank_drive #(
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 8,
  parameter int DATA_W    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BANKS-1:0] issue_i,
  input  logic                 we_i,
  input  logic [ROW_W-1:0]     row_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [NUM_BANKS-1:0] en_o,
  output logic                 we_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [DATA_W-1:0]    wdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      we_o    <= 1'b0;
      row_o   <= '0;
      wdata_o <= '0;
    end else begin
      en_o <= issue_i;
      // shared lines only move when some bank is strobed
      if (|issue_i) begin
        we_o    <= we_i;
        row_o   <= row_i;
        wdata_o <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/membank_router.sv
module membank_router #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16,
  parameter int BANK_W = 3
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           req_valid_i,
  output logic                           req_ready_o,
  input  logic                           req_we_i,
  input  logic [ADDR_W-1:0]              req_addr_i,
  input  logic [DATA_W-1:0]              req_wdata_i,
  output logic                           rsp_valid_o,
  output logic [DATA_W-1:0]              rsp_data_o,
  output logic [(1<<BANK_W)-1:0]         bank_en_o,
  output logic                           bank_we_o,
  output logic [ADDR_W-BANK_W-1:0]       bank_row_o,
  output logic [DATA_W-1:0]              bank_wdata_o,
  input  logic [(1<<BANK_W)-1:0]         bank_done_i,
  input  logic [(1<<BANK_W)*DATA_W-1:0]  bank_rdata_i
);
  localparam int NUM_BANKS   = 1 << BANK_W;
  localparam int ROW_W       = ADDR_W - BANK_W;
  localparam int ORDER_DEPTH = NUM_BANKS;

  logic [BANK_W-1:0]    sel;
  logic [ROW_W-1:0]     row;
  logic                 accept;
  logic [NUM_BANKS-1:0] issue_vec, pop_vec, slot_busy, slot_full;
  logic [DATA_W-1:0]    slot_data [NUM_BANKS];
  logic [BANK_W-1:0]    head_idx;
  logic                 fifo_empty, fifo_full, head_ready;

  assign sel         = req_addr_i[BANK_W-1:0];
  assign row         = req_addr_i[ADDR_W-1:BANK_W];
  assign req_ready_o = !slot_busy[sel] && (req_we_i || !fifo_full);
  assign accept      = req_valid_i && req_ready_o;
  assign head_ready  = !fifo_empty && slot_full[head_idx];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_slot
    assign issue_vec[b] = accept && (sel == BANK_W'(b));
    assign pop_vec[b]   = head_ready && (head_idx == BANK_W'(b));

    membank_slot #(.DATA_W(DATA_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .issue_i    (issue_vec[b]),
      .issue_we_i (req_we_i),
      .done_i     (bank_done_i[b]),
      .rdata_i    (bank_rdata_i[b*DATA_W +: DATA_W]),
      .pop_i      (pop_vec[b]),
      .busy_o     (slot_busy[b]),
      .full_o     (slot_full[b]),
      .data_o     (slot_data[b])
    );
  end

  membank_order_fifo #(.DEPTH(ORDER_DEPTH), .W(BANK_W)) u_order (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (accept && !req_we_i),
    .din_i   (sel),
    .pop_i   (head_ready),
    .dout_o  (head_idx),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  membank_drive #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_drive (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue_vec),
    .we_i    (req_we_i),
    .row_i   (row),
    .wdata_i (req_wdata_i),
    .en_o    (bank_en_o),
    .we_o    (bank_we_o),
    .row_o   (bank_row_o),
    .wdata_o (bank_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= head_ready;
      if (head_ready) rsp_data_o <= slot_data[head_idx];
    end
  end
endmodule

// File: rtl/membank_router_chk.sv
module membank_router_chk #(
  parameter int ADDR_W = 11,
  parameter int BANK_W = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_valid_i,
  input logic                    req_ready_o,
  input logic                    req_we_i,
  input logic [ADDR_W-1:0]       req_addr_i,
  input logic                    rsp_valid_o,
  input logic [(1<<BANK_W)-1:0]  bank_en_o
);
  localparam int NB    = 1 << BANK_W;
  localparam int CNT_W = $clog2(NB + 1) + 1;

  logic [CNT_W-1:0] rd_cnt_q;
  logic             acc;
  assign acc = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_cnt_q <= '0;
    else rd_cnt_q <= rd_cnt_q + CNT_W'(acc && !req_we_i) - CNT_W'(rsp_valid_o);
  end

  a_r3_en_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_en_o));

  a_r2_accept_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (bank_en_o == (NB'(1) << $past(req_addr_i[BANK_W-1:0]))));

  a_r3_no_stray_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> (bank_en_o == '0));

  a_r4_no_double_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bank_en_o & $past(bank_en_o)) == '0);

  a_r8_rsp_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rd_cnt_q != '0));

  a_r6_order_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_q <= CNT_W'(NB));
endmodule

bind membank_router membank_router_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_we_i    (req_we_i),
  .req_addr_i  (req_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .bank_en_o   (bank_en_o)
);

// File: tb/membank_router_bench.sv
module membank_router_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic         req_ready_o;
  logic         req_we_i = 1'b0;
  logic [10:0]  req_addr_i = '0;
  logic [15:0]  req_wdata_i = '0;
  logic         rsp_valid_o;
  logic [15:0]  rsp_data_o;
  logic [7:0]   bank_en_o;
  logic         bank_we_o;
  logic [7:0]   bank_row_o;
  logic [15:0]  bank_wdata_o;
  logic [7:0]   bank_done_i = '0;
  logic [127:0] bank_rdata_i = '0;

  membank_router u_membank_router (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_we_i(req_we_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .bank_en_o(bank_en_o), .bank_we_o(bank_we_o), .bank_row_o(bank_row_o),
    .bank_wdata_o(bank_wdata_o), .bank_done_i(bank_done_i), .bank_rdata_i(bank_rdata_i)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0;
  bit finished = 0;
  int lat_mode = 0;

  // bank behaviour
  logic [15:0] bmem [NB][256];
  logic [15:0] bdat [NB];
  int          bcnt [NB];
  // reference model
  logic [15:0] gold [2048];
  bit          m_busy [NB], m_rd [NB], m_full [NB];
  logic [15:0] m_hold [NB];
  int          ord [$];
  logic [15:0] rdq [$];
  logic [7:0]  exp_en = '0;
  logic        exp_we = 1'b0, exp_rv = 1'b0;
  logic [7:0]  exp_row = '0;
  logic [15:0] exp_wd = '0, exp_rd = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int pick_lat(input int b);
    case (lat_mode)
      1: return 1;
      2: return 4;
      3: return (b < 4) ? 4 : 1;
      default: return 1 + int'($urandom_range(0, 3));
    endcase
  endfunction

  task automatic cycle(input bit v, input bit we, input logic [10:0] a,
                       input logic [15:0] d, output bit acc);
    int bk;
    @(negedge clk_i);
    // registered outputs vs model
    chk(bank_en_o === exp_en, "R3", bank_en_o, exp_en);
    if (exp_en != 0) begin
      chk(bank_row_o === exp_row, "R2", bank_row_o, exp_row);
      chk(bank_we_o === exp_we, "R2", bank_we_o, exp_we);
      if (exp_we) chk(bank_wdata_o === exp_wd, "R2", bank_wdata_o, exp_wd);
    end
    chk(rsp_valid_o === exp_rv, "R7", rsp_valid_o, exp_rv);
    if (exp_rv) begin
      logic [15:0] g;
      chk(rsp_data_o === exp_rd, "R6", rsp_data_o, exp_rd);
      g = rdq.pop_front();
      chk(rsp_data_o === g, "R9", rsp_data_o, g);
    end
    // bank models
    for (int b = 0; b < NB; b++) begin
      bank_done_i[b] = 1'b0;
      if (bcnt[b] > 0) begin
        bcnt[b]--;
        if (bcnt[b] == 0) begin
          bank_done_i[b] = 1'b1;
          bank_rdata_i[b*16 +: 16] = bdat[b];
        end
      end
      if (bank_en_o[b]) begin
        bcnt[b] = pick_lat(b);
        if (bank_we_o) bmem[b][bank_row_o] = bank_wdata_o;
        else bdat[b] = bmem[b][bank_row_o];
      end
    end
    // stimulus
    req_valid_i = v; req_we_i = we; req_addr_i = a; req_wdata_i = d;
    #1;
    bk = int'(a[2:0]);
    chk(req_ready_o === !m_busy[bk], "R4", req_ready_o, !m_busy[bk]);
    acc = v && !m_busy[bk];
    // model edge
    exp_rv = 1'b0;
    if (ord.size() > 0 && m_full[ord[0]]) begin
      exp_rv = 1'b1;
      exp_rd = m_hold[ord[0]];
      m_full[ord[0]] = 0;
      m_busy[ord[0]] = 0;
      void'(ord.pop_front());
    end
    for (int b = 0; b < NB; b++)
      if (bank_done_i[b]) begin
        if (m_rd[b]) begin m_full[b] = 1; m_hold[b] = bank_rdata_i[b*16 +: 16]; end
        else m_busy[b] = 0;
      end
    exp_en = '0;
    if (acc) begin
      exp_en = 8'(1) << bk;
      exp_row = a[10:3]; exp_we = we; exp_wd = d;
      m_busy[bk] = 1; m_rd[bk] = !we;
      if (we) gold[a] = d;
      else begin ord.push_back(bk); rdq.push_back(gold[a]); end
    end
  endtask

  task automatic send(input bit we, input logic [10:0] a, input logic [15:0] d, output int waits);
    bit acc;
    waits = 0;
    do begin
      cycle(1'b1, we, a, d, acc);
      if (!acc) waits++;
    end while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, '0, '0, acc);
  endtask

  initial begin
    int w, tot;
    for (int a = 0; a < 2048; a++) begin
      gold[a] = 16'(a * 37) ^ 16'h5a5a;
      bmem[a % 8][a / 8] = gold[a];
    end
    for (int b = 0; b < NB; b++) begin
      bcnt[b] = 0; bdat[b] = '0; m_busy[b] = 0; m_rd[b] = 0; m_full[b] = 0; m_hold[b] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk(bank_en_o === 8'h00, "R1", bank_en_o, 0);
    chk(rsp_valid_o === 1'b0, "R1", rsp_valid_o, 0);
    chk(req_ready_o === 1'b1, "R1", req_ready_o, 1);

    // R5: eight banks in eight cycles, all still outstanding
    lat_mode = 2;
    tot = 0;
    for (int b = 0; b < NB; b++) begin send(1'b0, 11'(b + 40), '0, w); tot += w; end
    chk(tot == 0, "R5", tot, 0);
    idle(12);

    // R4: same bank back to back must stall
    send(1'b1, 11'd10, 16'hbeef, w);
    send(1'b0, 11'd18, '0, w);
    chk(w > 0, "R4", w, 1);
    send(1'b0, 11'd10, '0, w);
    chk(w > 0, "R4", w, 1);
    idle(10);

    // R6: later reads finish first
    lat_mode = 3;
    for (int r = 0; r < 4; r++)
      for (int b = 0; b < NB; b++) send(1'b0, 11'(r * 64 + b), '0, w);
    idle(12);

    // R8: write-only burst with single-cycle latency
    lat_mode = 1;
    for (int i = 0; i < 40; i++) send(1'b1, 11'($urandom_range(0, 2047)), 16'($urandom), w);
    idle(8);
    for (int i = 0; i < 40; i++) send(1'b0, 11'($urandom_range(0, 2047)), '0, w);
    idle(8);

    // R9: random mix, random latency, small address window for reuse
    lat_mode = 0;
    for (int i = 0; i < 3000; i++) begin
      bit acc;
      if ($urandom_range(0, 4) == 0) cycle(1'b0, 1'b0, '0, '0, acc);
      else send(1'($urandom_range(0, 1)), 11'($urandom_range(0, 63)), 16'($urandom), w);
    end
    idle(16);
    chk(rdq.size() == 0, "R6", rdq.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule